// File: doc/BRIEF.md
# Byte Codec Serial Port

This block is a full-duplex serial port for an external codec that exchanges 8-bit words. One programmable divider turns the system clock into a bit clock that both directions share. Every frame takes nine bit-clock periods. The first period carries a one-period sync pulse. The remaining eight periods carry one byte, most significant bit first. Outgoing bits change on the rising edge of the bit clock. Incoming bits are captured on the falling edge.

Software-side logic fills a 16-byte transmit queue and drains a 16-byte receive queue through plain strobe ports. A divider value and an enable complete the control. The divider value is captured only while the port is disabled. Disabling the port also resets the frame position, so a frame always starts cleanly after enable. If no byte is waiting when a frame's data begins, the port sends zero and raises a sticky underrun flag. That flag clears when the port is disabled.

Top module: `byte_codec_port`

## Requirements
- R1: After reset, codec_bclk, codec_sync, codec_dout and underrun are 0, tx_level and rx_level are 0, rx_empty is 1 and tx_full is 0.
- R2: With divider value N captured, codec_bclk stays high for N+1 clock cycles and low for N+1 clock cycles, giving a period of 2*(N+1) cycles. While enable is 0, codec_bclk is held low.
- R3: div_val is captured only while enable is 0. A change while enabled does not alter the bit-clock period.
- R4: A frame is nine bit-clock periods long. codec_sync is 1 for exactly the first period, so it stays high for 2*(N+1) clock cycles. It is followed by the eight data bits, bit 7 first. codec_sync and codec_dout change only together with a rising edge of codec_bclk.
- R5: codec_din is sampled on each falling edge of codec_bclk. The eight bits of the data periods form one byte, first bit as bit 7, and that byte is pushed to the receive queue after the eighth bit.
- R6: The transmit queue holds 16 bytes in write order. tx_full is 1 when tx_level is 16, and a write while full is ignored.
- R7: The receive queue holds 16 bytes. rx_data shows the oldest byte and a pulse on rx_rd removes it. A byte that arrives while the queue is full is dropped. A read while rx_empty is 1 is ignored.
- R8: If the transmit queue is empty when a frame's data begins, 0x00 is sent and underrun becomes 1. underrun stays 1 while enable is 1, even after new bytes are written, and returns to 0 once enable is 0.
- R9: Transmit and receive run at the same time. With codec_dout looped to codec_din, every byte sent is received unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the port; 0 stops the bit clock, resets framing and captures div_val |
| div_val | input | DIV_W | Divider value N; half bit-clock period is N+1 cycles |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_data | input | 8 | Byte to queue for transmission |
| tx_full | output | 1 | Transmit queue holds 16 bytes |
| tx_level | output | $clog2(DEPTH)+1 | Bytes waiting in the transmit queue |
| rx_rd | input | 1 | Removes the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue is empty |
| rx_level | output | $clog2(DEPTH)+1 | Bytes waiting in the receive queue |
| underrun | output | 1 | Sticky flag: a frame started with nothing to send |
| codec_bclk | output | 1 | Shared bit clock to the codec |
| codec_sync | output | 1 | Frame sync, high during the period before bit 7 |
| codec_dout | output | 1 | Serial data to the codec |
| codec_din | input | 1 | Serial data from the codec |

## Verification
The hardest situation to reach is a queue boundary in the middle of live serial traffic. This covers a receive queue that overflows while frames keep arriving, and a transmit queue that runs dry at a frame start and is then refilled while the port is still running. The bench loops codec_dout back to codec_din and preloads the transmit queue while the port is disabled. It then lets the port run until exactly 16 bytes have returned and keeps it running past that point, so the extra frames, carrying underrun zeros, meet a full receive queue. A separate run starts with an empty queue to raise underrun and then writes a byte during traffic. An independent monitor decodes the wire frames and times the sync width. A sweep of divider values checks the bit-clock period, including a divider change made while the port is enabled.

// File: rtl/byte_codec_port.sv
module byte_codec_port #(
  parameter int DIV_W = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [DIV_W-1:0]         div_val,
  input  logic                     tx_wr,
  input  logic [7:0]               tx_data,
  output logic                     tx_full,
  output logic [$clog2(DEPTH):0]   tx_level,
  input  logic                     rx_rd,
  output logic [7:0]               rx_data,
  output logic                     rx_empty,
  output logic [$clog2(DEPTH):0]   rx_level,
  output logic                     underrun,
  output logic                     codec_bclk,
  output logic                     codec_sync,
  output logic                     codec_dout,
  input  logic                     codec_din
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [3:0] LAST = 4'd8;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DIV_W-1:0] div_q, cnt;
  logic             bclk_q, sync_q, dout_q;
  logic [3:0]       slot;
  logic [7:0]       tx_sh, rx_sh;

  wire tick = enable && (cnt == div_q);
  wire rise = tick && !bclk_q;
  wire fall = tick && bclk_q;

  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [LW-1:0] tx_cnt;
  wire tx_push = tx_wr && !tx_full;
  wire tx_take = rise && (slot == 4'd0);
  wire tx_pop  = tx_take && (tx_cnt != '0);
  wire [7:0] tx_byte = (tx_cnt == '0) ? 8'h00 : tx_mem[tx_rp];

  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [LW-1:0] rx_cnt;
  wire rx_push = fall && (slot == LAST) && (rx_cnt != LW'(DEPTH));
  wire rx_pop  = rx_rd && (rx_cnt != '0);

  assign tx_full    = (tx_cnt == LW'(DEPTH));
  assign tx_level   = tx_cnt;
  assign rx_empty   = (rx_cnt == '0);
  assign rx_level   = rx_cnt;
  assign rx_data    = rx_mem[rx_rp];
  assign codec_bclk = bclk_q;
  assign codec_sync = sync_q;
  assign codec_dout = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; cnt <= '0; bclk_q <= 1'b0; slot <= LAST;
      sync_q <= 1'b0; dout_q <= 1'b0; tx_sh <= '0; rx_sh <= '0;
    end else if (!enable) begin
      div_q <= div_val; cnt <= '0; bclk_q <= 1'b0; slot <= LAST;
      sync_q <= 1'b0; dout_q <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) bclk_q <= ~bclk_q;
      if (rise) begin
        slot   <= (slot == LAST) ? 4'd0 : slot + 4'd1;
        sync_q <= (slot == LAST);
        if (slot == LAST) begin
          dout_q <= 1'b0;
        end else if (slot == 4'd0) begin
          dout_q <= tx_byte[7];
          tx_sh  <= {tx_byte[6:0], 1'b0};
        end else begin
          dout_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
      end
      if (fall) rx_sh <= {rx_sh[6:0], codec_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underrun <= 1'b0;
    else if (!enable) underrun <= 1'b0;
    else if (tx_take && tx_cnt == '0) underrun <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + LW'(tx_push) - LW'(tx_pop);
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + LW'(rx_push) - LW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_data;
    if (rx_push) rx_mem[rx_wp] <= {rx_sh[6:0], codec_din};
  end

  // R2
  bclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !codec_bclk);

  // R4
  sync_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_sync) |-> $rose(codec_bclk));

  // R4
  dout_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    ($past(enable) && !$stable(codec_dout)) |-> $rose(codec_bclk));

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && enable) |=> underrun);

  // R6
  tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH));

  // R7
  rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));
endmodule

// File: tb/test_byte_codec_port.sv
module test_byte_codec_port;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [7:0] div_val = '0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_full, rx_empty, underrun, codec_bclk, codec_sync, codec_dout;
  logic [4:0] tx_level, rx_level;
  logic [7:0] rx_data;

  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  byte_codec_port i_byte_codec_port (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .tx_level(tx_level),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty), .rx_level(rx_level),
    .underrun(underrun), .codec_bclk(codec_bclk), .codec_sync(codec_sync),
    .codec_dout(codec_dout), .codec_din(codec_dout));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
  endtask

  // wire monitor: decodes frames and times sync width (R4)
  logic       mon_on = 1'b0, mb_prev = 1'b0;
  int         mbit = -1, mk = 0, shigh = 0, mon_n = 0;
  logic [7:0] mbyte = '0;
  logic [7:0] exp_q [16];

  always @(negedge clk) begin
    if (!enable) mbit = -1;
    if (mon_on && enable) begin
      if (codec_sync) shigh++;
      else if (shigh > 0) begin
        chk(shigh == 2 * (mon_n + 1), "R4 sync width", shigh, 2 * (mon_n + 1));
        shigh = 0;
      end
      if (codec_bclk && !mb_prev) begin
        if (codec_sync) begin
          mbit = 0; mbyte = '0;
        end else if (mbit >= 0 && mbit < 8) begin
          mbyte = {mbyte[6:0], codec_dout};
          mbit++;
          if (mbit == 8) begin
            chk(mbyte == ((mk < 16) ? exp_q[mk] : 8'h00), "R4 wire byte",
                mbyte, (mk < 16) ? exp_q[mk] : 0);
            mk++;
            mbit = -1;
          end
        end
      end
    end else shigh = 0;
    mb_prev = codec_bclk;
  end

  task automatic wr(input logic [7:0] v);
    tx_wr = 1'b1; tx_data = v;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] exp, input string req);
    chk(rx_data == exp, req, rx_data, exp);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic period(input int n);
    int h, l;
    enable = 1'b0; div_val = 8'(n);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    while (!codec_bclk) @(negedge clk);
    div_val = 8'(n + 3);
    for (int rep = 0; rep < 2; rep++) begin
      h = 0; l = 0;
      while (codec_bclk) begin h++; @(negedge clk); end
      while (!codec_bclk) begin l++; @(negedge clk); end
      if (rep == 0) begin
        chk(h == n + 1, "R2 high time", h, n + 1);
        chk(l == n + 1, "R2 low time", l, n + 1);
      end else
        chk(h + l == 2 * (n + 1), "R3 period after live div change", h + l, 2 * (n + 1));
    end
    enable = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(codec_bclk == 1'b0, "R2 idle low", codec_bclk, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report;
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R1
    chk(codec_bclk == 0 && codec_sync == 0 && codec_dout == 0, "R1 lines", codec_bclk, 0);
    chk(underrun == 0, "R1 underrun", underrun, 0);
    chk(tx_level == 0 && rx_level == 0, "R1 levels", tx_level + rx_level, 0);
    chk(rx_empty == 1 && tx_full == 0, "R1 flags", rx_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < 8; n++) period(n);

    // R9 / R5 / R4: loopback sweep of all 256 byte values, divider 1
    mon_n = 1;
    for (int g = 0; g < 16; g++) begin
      enable = 1'b0; div_val = 8'd1;
      @(negedge clk);
      for (int i = 0; i < 16; i++) begin
        exp_q[i] = 8'(g * 16 + i);
        wr(exp_q[i]);
      end
      mk = 0; mon_on = 1'b1;
      enable = 1'b1;
      while (rx_level != 16) @(negedge clk);
      enable = 1'b0; mon_on = 1'b0;
      @(negedge clk);
      chk(mk == 16, "R4 frame count", mk, 16);
      for (int i = 0; i < 16; i++) rd(exp_q[i], "R9 loopback byte");
      chk(rx_empty == 1, "R7 drained", rx_empty, 1);
    end

    // R6 / R7 / R8: full transmit queue, overflowing receive queue
    enable = 1'b0; div_val = 8'd0; mon_n = 0;
    @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      if (i < 16) exp_q[i] = 8'hA0 + 8'(i);
      wr(8'hA0 + 8'(i));
      chk(tx_level == 5'((i < 16) ? i + 1 : 16), "R6 level", tx_level, (i < 16) ? i + 1 : 16);
    end
    chk(tx_full == 1, "R6 full flag", tx_full, 1);
    mk = 0; mon_on = 1'b1;
    enable = 1'b1;
    while (rx_level != 16) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(underrun == 1, "R8 underrun after drain", underrun, 1);
    chk(rx_level == 16, "R7 overflow dropped", rx_level, 16);
    enable = 1'b0; mon_on = 1'b0;
    @(negedge clk);
    chk(underrun == 0, "R8 clear on disable", underrun, 0);
    for (int i = 0; i < 16; i++) rd(exp_q[i], "R6 order kept, R7 extra dropped");
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk(rx_level == 0 && rx_empty == 1, "R7 read on empty", rx_level, 0);

    // R8: start empty, then refill while running
    div_val = 8'd1;
    @(negedge clk);
    enable = 1'b1;
    while (rx_level < 2) @(negedge clk);
    chk(underrun == 1, "R8 set", underrun, 1);
    rd(8'h00, "R8 zero byte");
    rd(8'h00, "R8 zero byte");
    wr(8'h5A);
    repeat (120) @(negedge clk);
    chk(underrun == 1, "R8 sticky", underrun, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(underrun == 0, "R8 cleared", underrun, 0);
    seen = 1'b0;
    for (int i = 0; i < 16 && !rx_empty; i++) begin
      if (rx_data == 8'h5A) seen = 1'b1;
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
    end
    chk(seen, "R9 refill byte received", seen, 1);

    report;
    $finish;
  end
endmodule